// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the controller side of a receive descriptor ring kept in shared memory. The host builds a ring of 2^N four-word descriptors and sets the ownership flag on each one it offers. It then loads the ring base and the log2 ring size through a single initialization strobe. When a frame starts on the byte stream, the block reads the status word of the current descriptor. If the controller owns it, the block fetches the buffer length and counts the frame's bytes until the end-of-frame strobe. It then writes back the byte count and a status byte that clears ownership, raises a one-cycle receive-done pulse and moves to the next descriptor, wrapping modulo the ring size.

If the current descriptor still belongs to the host, the frame is dropped. In that case the block writes nothing, raises a one-cycle missed-frame pulse and stays on the same descriptor, so the next frame retries it. Each frame is assumed to fit one descriptor; frame data movement is handled elsewhere. The memory port is synchronous: read data is valid in the cycle after a read request.

Top module: `rxr_ring_writer`

## Requirements
- R1: An `init_load` pulse sets the ring log2 size from `init_len_word[15:13]`. It sets the descriptor ring word address to {`init_len_word[7:0]`, `init_base_lo`} with its two low bits forced to zero, and it resets the ring index to 0.
- R2: Descriptor i occupies the four words at base + 4*i. Word +0 holds the buffer address low part. Word +1 holds the status byte in bits [15:8] and the address high byte in [7:0]. Word +2 holds the buffer length. Word +3 holds the message byte count. Words +0 and +2 are never written.
- R3: At a frame start the block reads word +1. If status bit 7 (OWN, word bit 15) is 0, `miss` pulses for exactly one cycle and no memory write occurs for that frame.
- R4: The buffer length is the 16-bit two's-complement negation of word +2, taken in its low 12 bits (so 0xFA00 means 1536 bytes).
- R5: Word +3 is written with the number of bytes in the frame, FCS bytes included, in bits [11:0], with bits [15:12] zero.
- R6: When the frame has more bytes than the buffer length, status bit 4 (overflow) is set and the written count equals the buffer length.
- R7: The written status byte has bit 7 (OWN) cleared and bits 1 and 0 (start and end of frame) set. Bit 5 is the framing-error input and bit 3 the CRC-error input, both as given with the end strobe. Bit 2 is zero. Bit 6 is the OR of bits 5, 4, 3 and 2. The address high byte in word +1 is kept unchanged.
- R8: The count word is written in the cycle before the status word. `rint` pulses for exactly one cycle, in the cycle after the status write.
- R9: After each write-back the index becomes (index + 1) AND (2^N - 1), so the ring wraps from its last descriptor to descriptor 0.
- R10: After a missed frame the index is unchanged, and the next frame uses the same descriptor once the host has set its OWN bit.
- R11: Frames of one or two bytes, whose end strobe arrives before the ownership check and length fetch finish, are written back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_load | input | 1 | Load ring parameters, reset the index |
| init_base_lo | input | 16 | Low part of the ring base word address |
| init_len_word | input | 16 | [15:13] log2 ring size, [7:0] high part of the ring base |
| rx_byte | input | 1 | One frame byte received this cycle |
| rx_eof | input | 1 | The byte this cycle is the last of the frame |
| rx_fra_err | input | 1 | Framing error, valid with the end strobe |
| rx_crc_err | input | 1 | CRC error, valid with the end strobe |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Descriptor memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| rint | output | 1 | One-cycle pulse after a descriptor write-back |
| miss | output | 1 | One-cycle pulse when a frame finds no owned descriptor |

## Verification
The bench aims at the exact-fit and one-over buffer lengths. A design that compares off by one would flag overflow on a frame that fits, or write a count larger than the buffer. Single-byte frames end before the length fetch returns; a design that only watches the end strobe in its receive state would hang and never pulse `rint`. A descriptor left with the host must produce a miss with untouched memory and no index advance; a wrong design would overwrite host-owned words or skip ahead in the ring. Ring wrap, a reload that resets the index, and a misaligned base whose low bits must be dropped are also covered, so a wrong mask or a stale index shows up as a write to the wrong descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  // word offsets inside one descriptor
  localparam logic [1:0] OFF_BADDR = 2'd0;
  localparam logic [1:0] OFF_STAT  = 2'd1;
  localparam logic [1:0] OFF_BLEN  = 2'd2;
  localparam logic [1:0] OFF_MCNT  = 2'd3;

  // bit positions inside the status byte
  localparam int ST_OWN = 7;
  localparam int ST_ERR = 6;
  localparam int ST_FRA = 5;
  localparam int ST_OFL = 4;
  localparam int ST_CRC = 3;
  localparam int ST_BUF = 2;
  localparam int ST_SOP = 1;
  localparam int ST_EOP = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_LEN,
    S_GOT_LEN,
    S_RECV,
    S_DROP,
    S_WR_CNT,
    S_WR_STAT
  } rxr_state_e;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int LO_W   = 16,
  parameter int HI_W   = 8,
  parameter int LOG2_W = 3,
  localparam int ADDR_W = LO_W + HI_W,
  localparam int IDX_W  = (1 << LOG2_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic [ADDR_W-3:0] init_base,
  input  logic [LOG2_W-1:0] init_log2,
  input  logic              advance,
  output logic [ADDR_W-1:0] desc_addr
);

  logic [ADDR_W-3:0] base_q;
  logic [LOG2_W-1:0] log2_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W:0]    size_v;
  logic [IDX_W-1:0]  mask_v;

  always_comb begin
    size_v = (IDX_W+1)'(1) << log2_q;
    mask_v = IDX_W'(size_v - 1'b1);
    idx_d  = idx_q;
    if (init_load)
      idx_d = '0;
    else if (advance)
      idx_d = (idx_q + 1'b1) & mask_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      log2_q <= '0;
    end else if (init_load) begin
      base_q <= init_base;
      log2_q <= init_log2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (init_load || advance)
      idx_q <= idx_d;
  end

  assign desc_addr = {base_q, 2'b00} + ADDR_W'({idx_q, 2'b00});

endmodule

// File: rtl/rxr_frame_cnt.sv
module rxr_frame_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             rx_byte,
  input  logic             rx_eof,
  input  logic             rx_fra_err,
  input  logic             rx_crc_err,
  output logic [CNT_W-1:0] count,
  output logic             done_now,
  output logic             fra_q,
  output logic             crc_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             done_q, done_d, fra_d, crc_d, take;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    take   = accept && rx_byte && !done_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    fra_d  = fra_q;
    crc_d  = crc_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
      fra_d  = 1'b0;
      crc_d  = 1'b0;
    end else if (take) begin
      if (cnt_q != CNT_MAX)
        cnt_d = cnt_q + 1'b1;
      if (rx_eof) begin
        done_d = 1'b1;
        fra_d  = rx_fra_err;
        crc_d  = rx_crc_err;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      fra_q  <= 1'b0;
      crc_q  <= 1'b0;
    end else if (clr || take) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      fra_q  <= fra_d;
      crc_q  <= crc_d;
    end
  end

  assign count    = cnt_q;
  assign done_now = done_q || (take && rx_eof);

endmodule

// File: rtl/rxr_desc_fsm.sv
module rxr_desc_fsm
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte,
  input  logic              done_now,
  input  logic [CNT_W-1:0]  count,
  input  logic              fra_q,
  input  logic              crc_q,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [15:0]       mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              advance,
  output logic              clr,
  output logic              accept,
  output logic              rint,
  output logic              miss
);

  rxr_state_e       state_q, state_d;
  logic [7:0]       hadr_q;
  logic [CNT_W-1:0] blen_q;
  logic             hadr_ld, blen_ld, rint_d, miss_d, ofl;
  logic [CNT_W-1:0] cnt_out;
  logic [7:0]       status;

  always_comb begin
    ofl     = count > blen_q;
    cnt_out = ofl ? blen_q : count;
    status  = '0;
    status[ST_FRA] = fra_q;
    status[ST_OFL] = ofl;
    status[ST_CRC] = crc_q;
    status[ST_ERR] = fra_q || ofl || crc_q || status[ST_BUF];
    status[ST_SOP] = 1'b1;
    status[ST_EOP] = 1'b1;
  end

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    advance   = 1'b0;
    hadr_ld   = 1'b0;
    blen_ld   = 1'b0;
    rint_d    = 1'b0;
    miss_d    = 1'b0;
    unique case (state_q)
      S_IDLE: if (rx_byte) state_d = S_RD_STAT;
      S_RD_STAT: begin
        mem_req  = 1'b1;
        mem_addr = {desc_addr[ADDR_W-1:2], OFF_STAT};
        state_d  = S_RD_LEN;
      end
      S_RD_LEN: begin
        if (mem_rdata[8+ST_OWN]) begin
          hadr_ld  = 1'b1;
          mem_req  = 1'b1;
          mem_addr = {desc_addr[ADDR_W-1:2], OFF_BLEN};
          state_d  = S_GOT_LEN;
        end else begin
          miss_d  = 1'b1;
          state_d = done_now ? S_IDLE : S_DROP;
        end
      end
      S_GOT_LEN: begin
        blen_ld = 1'b1;
        state_d = done_now ? S_WR_CNT : S_RECV;
      end
      S_RECV:  if (done_now) state_d = S_WR_CNT;
      S_DROP:  if (done_now) state_d = S_IDLE;
      S_WR_CNT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {desc_addr[ADDR_W-1:2], OFF_MCNT};
        mem_wdata = {{(16-CNT_W){1'b0}}, cnt_out};
        state_d   = S_WR_STAT;
      end
      S_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {desc_addr[ADDR_W-1:2], OFF_STAT};
        mem_wdata = {status, hadr_q};
        advance   = 1'b1;
        rint_d    = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
    clr    = (state_q != S_IDLE) && (state_d == S_IDLE);
    accept = (state_q != S_WR_CNT) && (state_q != S_WR_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rint    <= 1'b0;
      miss    <= 1'b0;
    end else begin
      state_q <= state_d;
      rint    <= rint_d;
      miss    <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hadr_q <= '0;
    else if (hadr_ld)
      hadr_q <= mem_rdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blen_q <= '0;
    else if (blen_ld)
      blen_q <= CNT_W'(~mem_rdata + 16'd1);
  end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int LO_W   = 16,
  parameter int HI_W   = 8,
  parameter int LOG2_W = 3,
  parameter int CNT_W  = 12,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic [LO_W-1:0]   init_base_lo,
  input  logic [15:0]       init_len_word,
  input  logic              rx_byte,
  input  logic              rx_eof,
  input  logic              rx_fra_err,
  input  logic              rx_crc_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rint,
  output logic              miss
);

  logic [ADDR_W-1:0] desc_addr;
  logic [CNT_W-1:0]  count;
  logic              advance, clr, accept, done_now, fra_q, crc_q;
  logic              unused_bits;

  assign unused_bits = ^{init_len_word[15-LOG2_W:HI_W], init_base_lo[1:0]};

  rxr_ring_ptr #(.LO_W(LO_W), .HI_W(HI_W), .LOG2_W(LOG2_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_load (init_load),
    .init_base ({init_len_word[HI_W-1:0], init_base_lo[LO_W-1:2]}),
    .init_log2 (init_len_word[15:16-LOG2_W]),
    .advance   (advance),
    .desc_addr (desc_addr)
  );

  rxr_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .accept     (accept),
    .rx_byte    (rx_byte),
    .rx_eof     (rx_eof),
    .rx_fra_err (rx_fra_err),
    .rx_crc_err (rx_crc_err),
    .count      (count),
    .done_now   (done_now),
    .fra_q      (fra_q),
    .crc_q      (crc_q)
  );

  rxr_desc_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .done_now  (done_now),
    .count     (count),
    .fra_q     (fra_q),
    .crc_q     (crc_q),
    .desc_addr (desc_addr),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .advance   (advance),
    .clr       (clr),
    .accept    (accept),
    .rint      (rint),
    .miss      (miss)
  );

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              rint,
  input logic              miss
);

  logic stat_wr, cnt_wr;
  assign stat_wr = mem_req && mem_we && (mem_addr[1:0] == 2'd1);
  assign cnt_wr  = mem_req && mem_we && (mem_addr[1:0] == 2'd3);

  // R2: descriptor words +0 and +2 are never written
  a_r2_no_len_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_addr[0]);

  // R3: the miss pulse lasts one cycle and carries no write
  a_r3_miss_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);
  a_r3_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !(mem_req && mem_we));

  // R5: count word upper bits are zero
  a_r5_cnt_upper: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> (mem_wdata[15:12] == 4'h0));

  // R7: ownership returned, SOP and EOP set, BUF clear, ERR summarises
  a_r7_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (!mem_wdata[15] && mem_wdata[9:8] == 2'b11 && !mem_wdata[10]));
  a_r7_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (mem_wdata[14] == (|mem_wdata[13:10])));

  // R8: count then status, then a single-cycle rint
  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> stat_wr);
  a_r8_rint_after: assert property (@(posedge clk) disable iff (!rst_n)
    rint |-> $past(stat_wr));
  a_r8_rint_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rint |=> !rint);
  a_r8_rint_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rint && miss));

endmodule

bind rxr_ring_writer rxr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rint      (rint),
  .miss      (miss)
);

// File: tb/tb_rxr_ring_writer.sv
module tb_rxr_ring_writer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_load;
  logic [15:0] init_base_lo, init_len_word;
  logic        rx_byte, rx_eof, rx_fra_err, rx_crc_err;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        rint, miss;

  logic        host_we;
  logic [11:0] host_addr;
  logic [15:0] host_data;
  logic [15:0] mem [4096];

  int checks = 0, fails = 0;
  int rint_seen = 0, miss_seen = 0, hi_bad = 0;
  logic [7:0] exp_hi = 8'h00;
  int ring_base, ring_log2, ring_idx;

  always #4 clk = ~clk;

  rxr_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_base_lo(init_base_lo),
    .init_len_word(init_len_word), .rx_byte(rx_byte), .rx_eof(rx_eof),
    .rx_fra_err(rx_fra_err), .rx_crc_err(rx_crc_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rint(rint), .miss(miss)
  );

  always @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  always @(negedge clk) begin
    if (rint) rint_seen++;
    if (miss) miss_seen++;
    if (mem_req && mem_addr[23:16] != exp_hi) hi_bad++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input bit fra, input bit crc, input bit ofl);
    exp_status = {1'b0, fra | crc | ofl, fra, ofl, crc, 1'b0, 1'b1, 1'b1};
  endfunction

  task automatic host_write(input int a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 12'(a); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic setup_ring(input int base, input int lg, input int blen);
    for (int i = 0; i < (1 << lg); i++) begin
      host_write(base + 4*i,     16'(16'h1000 + i*16'h0600));
      host_write(base + 4*i + 1, {8'h80, 8'(8'h30 + i)});
      host_write(base + 4*i + 2, (16'd0 - 16'(blen)) | 16'hF000);
      host_write(base + 4*i + 3, 16'h0000);
    end
  endtask

  task automatic do_init(input logic [15:0] lo, input logic [15:0] lw);
    @(negedge clk);
    init_load = 1'b1; init_base_lo = lo; init_len_word = lw;
    @(negedge clk);
    init_load = 1'b0;
  endtask

  task automatic arm(input int idx);
    int d;
    d = ring_base + 4*idx;
    host_write(d + 1, {8'h80, mem[d+1][7:0]});
    host_write(d + 3, 16'h0000);
  endtask

  task automatic run_frame(input int len, input bit fra, input bit crc);
    int d, r0, m0, blen, ec;
    logic [15:0] w0, w1, w2, w3, nb;
    bit own, ofl;
    d  = ring_base + 4*ring_idx;
    w0 = mem[d]; w1 = mem[d+1]; w2 = mem[d+2]; w3 = mem[d+3];
    own = w1[15];
    nb = 16'd0 - w2;
    blen = int'(nb[11:0]);
    r0 = rint_seen; m0 = miss_seen;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_byte = 1'b1;
      rx_eof = (i == len - 1);
      rx_fra_err = (i == len - 1) ? fra : 1'b0;
      rx_crc_err = (i == len - 1) ? crc : 1'b0;
    end
    @(negedge clk);
    rx_byte = 1'b0; rx_eof = 1'b0; rx_fra_err = 1'b0; rx_crc_err = 1'b0;
    repeat (12) @(negedge clk);
    if (own) begin
      ofl = len > blen;
      ec  = ofl ? blen : len;
      chk(rint_seen - r0 == 1, "R8 rint pulses", rint_seen - r0, 1);
      chk(miss_seen == m0, "R3 no miss when owned", miss_seen - m0, 0);
      chk(mem[d+3] == 16'(ec), "R5/R6 count word", int'(mem[d+3]), ec);
      chk(mem[d+1] == {exp_status(fra, crc, ofl), w1[7:0]}, "R7 status word",
          int'(mem[d+1]), int'({exp_status(fra, crc, ofl), w1[7:0]}));
      chk(mem[d] == w0 && mem[d+2] == w2, "R2 words 0 and 2 kept", int'(mem[d+2]), int'(w2));
      ring_idx = (ring_idx + 1) & ((1 << ring_log2) - 1);
    end else begin
      chk(miss_seen - m0 == 1, "R3 miss pulse", miss_seen - m0, 1);
      chk(rint_seen == r0, "R3 no rint on miss", rint_seen - r0, 0);
      chk(mem[d+1] == w1 && mem[d+3] == w3, "R10 descriptor untouched", int'(mem[d+3]), int'(w3));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; init_load = 1'b0; init_base_lo = '0; init_len_word = '0;
    rx_byte = 1'b0; rx_eof = 1'b0; rx_fra_err = 1'b0; rx_crc_err = 1'b0;
    host_we = 1'b0; host_addr = '0; host_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rint && !miss && !mem_req, "R8/R3 reset state", {rint, miss, mem_req}, 0);

    // ring A: 4 descriptors, 64-byte buffers
    ring_base = 16'h0100; ring_log2 = 2; ring_idx = 0;
    setup_ring(ring_base, ring_log2, 64);
    do_init(16'h0100, {3'd2, 5'd0, 8'h00});
    run_frame(10, 0, 0);                // R5 plain frame
    run_frame(64, 0, 0);                // R4 exact fit, no overflow
    run_frame(65, 0, 0);                // R6 one over
    run_frame(1, 0, 0);                 // R11 single byte
    arm(0); arm(1); arm(2); arm(3);
    run_frame(2, 0, 1);                 // R9 wrap to descriptor 0, R11, CRC error
    run_frame(30, 1, 0);                // R7 framing error
    arm(1);
    run_frame(20, 0, 0);                // descriptor 2
    host_write(ring_base + 4*3 + 1, {8'h00, mem[ring_base + 13][7:0]});
    run_frame(15, 0, 0);                // R3 miss on host-owned descriptor
    arm(3);
    run_frame(12, 1, 1);                // R10 retry same descriptor
    chk(ring_idx == 0, "R9 bench index wrapped", ring_idx, 0);

    // ring B: misaligned base, high bits, 8 descriptors, reload resets index (R1)
    ring_base = 16'h0200; ring_log2 = 3; ring_idx = 0;
    setup_ring(ring_base, ring_log2, 100);
    exp_hi = 8'h5A;
    do_init(16'h0203, {3'd3, 5'd0, 8'h5A});
    run_frame(40, 0, 0);                // R1 index restarts at 0
    for (int n = 0; n < 60; n++) begin
      int len;
      bit fra, crc;
      if (!mem[ring_base + 4*ring_idx + 1][15] && ($urandom % 2 == 0)) arm(ring_idx);
      len = 1 + int'($urandom % 110);
      fra = ($urandom % 8) == 0;
      crc = ($urandom % 8) == 0;
      begin
        int prev;
        prev = ring_idx;
        run_frame(len, fra, crc);
        if (prev != ring_idx && ($urandom % 4) != 0) arm(prev);
      end
    end
    chk(hi_bad == 0, "R1 high address byte", hi_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule